// File: doc/BRIEF.md
# Emulation External Bus Controller

This block lets an 8-bit microcontroller core run with its program store held off-chip. Each bus cycle the core issues carries a 12-bit address, a read/write flag, write data and an opcode-fetch flag. The block sorts the address into one of three regions. Two regions are sent to the external memory bus: the program window and a debug-only window below it. The third region, internal RAM, I/O and the vector area, is served on-chip.

The bus request is registered once, so every external output shows a request one clock after the core presents it. Writes to internal locations go to the on-chip select lines and are also shown on the external bus, so an emulator or logic analyser can follow them. Internal reads never show on the external bus. A ready input stretches external and internal read cycles: while it is low the core is stalled and the registered cycle is held. Writes do not wait for it.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: Addresses 0x800 to 0xFF9 are external. A read there asserts `ext_strobe_o`, drives `ext_addr_o` with the address and `ext_rnw_o` high, and returns `ext_din_i` on `cpu_rdata_o`.
- R2: Addresses 0x400 to 0x7FF form the debug window. They are external with the same read and write behaviour as R1.
- R3: Addresses 0x000 to 0x3FF and 0xFFA to 0xFFF are internal. A read there asserts `int_sel_o`, leaves `ext_strobe_o` low, `ext_addr_o` at zero and `ext_rnw_o` high, and returns `int_rdata_i` on `cpu_rdata_o`.
- R4: A write to an internal address asserts `int_sel_o` and `int_we_o`. It is also mirrored externally: `ext_strobe_o` high, `ext_rnw_o` low, address on `ext_addr_o` and the data on `ext_dout_o`.
- R5: `ext_doe_o` is high only in visible write cycles (external or mirrored). `ext_dout_o` is zero whenever `ext_doe_o` is low.
- R6: A write to an external address drives the external bus with `ext_doe_o` high and leaves `int_sel_o` and `int_we_o` low.
- R7: `ext_sync_o` follows the opcode-fetch flag of the registered cycle one-to-one. This holds for every region, including internal reads.
- R8: When `ext_rdy_i` is low and the registered cycle is a read, `cpu_stall_o` is high and the registered cycle, with all its outputs, is held. `ext_rdy_i` has no effect on write cycles.
- R9: While `rst_n` is low the bus is idle: `ext_strobe_o` low, `ext_rnw_o` high, `ext_doe_o` low, `ext_sync_o`, `int_sel_o` and `cpu_stall_o` low.
- R10: A clock in which `cpu_valid_i` is low yields an idle cycle one clock later, with the same outputs as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Core issues a bus cycle |
| cpu_addr_i | input | 12 | Core address |
| cpu_rnw_i | input | 1 | 1 = read, 0 = write |
| cpu_wdata_i | input | 8 | Core write data |
| cpu_sync_i | input | 1 | Cycle is an opcode fetch |
| cpu_rdata_o | output | 8 | Read data to the core |
| cpu_stall_o | output | 1 | Core must hold its request |
| int_rdata_i | input | 8 | Read data from internal RAM and I/O |
| int_sel_o | output | 1 | Internal location selected |
| int_we_o | output | 1 | Internal write strobe |
| ext_addr_o | output | 12 | External address |
| ext_dout_o | output | 8 | External write data |
| ext_doe_o | output | 1 | External data driver enable |
| ext_din_i | input | 8 | External read data |
| ext_rnw_o | output | 1 | External read/write, high reads |
| ext_strobe_o | output | 1 | External bus cycle active |
| ext_sync_o | output | 1 | Opcode-fetch indication to the external bus |
| ext_rdy_i | input | 1 | External ready, low stalls reads |

## Verification
Directed cycles sit on each window edge: 0x3FF/0x400, 0x7FF/0x800 and 0xFF9/0xFFA. Each is tried with reads and writes, so an off-by-one bound shows up as a strobe or data-source mismatch. A random mix follows, weighted toward those edges, with random ready, valid and fetch flags. It tells internal reads, mirrored writes and external traffic apart by strobe, data enable and read-data source. Ready-low stretches during reads show whether the held cycle survives changing core inputs, and ready-low during writes shows whether it wrongly stalls.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   typedef enum logic [1:0] {
      RGN_INT  = 2'd0,
      RGN_PROG = 2'd1,
      RGN_DBG  = 2'd2
   } rgn_e;

   typedef struct packed {
      logic valid;
      logic rnw;
      logic sync;
      rgn_e rgn;
   } ctl_t;

endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
   import ebc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int PROG_LO = 'h800,
   parameter int PROG_HI = 'hFF9,
   parameter int DBG_LO  = 'h400,
   parameter int DBG_HI  = 'h7FF,
   parameter bit DBG_EN  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output rgn_e              rgn_o
);

   localparam logic [ADDR_W-1:0] P_LO = ADDR_W'(PROG_LO);
   localparam logic [ADDR_W-1:0] P_HI = ADDR_W'(PROG_HI);
   localparam logic [ADDR_W-1:0] D_LO = ADDR_W'(DBG_LO);
   localparam logic [ADDR_W-1:0] D_HI = ADDR_W'(DBG_HI);

   if (PROG_LO > PROG_HI) begin : g_bad_prog
      $error("program window bounds reversed");
   end
   if (DBG_EN && (DBG_LO > DBG_HI || DBG_HI >= PROG_LO)) begin : g_bad_dbg
      $error("debug window must lie below the program window");
   end

   logic in_prog;
   logic in_dbg;

   assign in_prog = (addr_i >= P_LO) && (addr_i <= P_HI);

   if (DBG_EN) begin : g_dbg
      assign in_dbg = (addr_i >= D_LO) && (addr_i <= D_HI);
   end else begin : g_nodbg
      assign in_dbg = 1'b0;
   end

   always_comb begin
      if (in_prog)     rgn_o = RGN_PROG;
      else if (in_dbg) rgn_o = RGN_DBG;
      else             rgn_o = RGN_INT;
   end

endmodule

// File: rtl/ebc_cycle_reg.sv
module ebc_cycle_reg
   import ebc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy_i,
   input  ctl_t              nxt_ctl_i,
   input  logic [ADDR_W-1:0] nxt_addr_i,
   input  logic [DATA_W-1:0] nxt_data_i,
   output ctl_t              cur_ctl_o,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [DATA_W-1:0] cur_data_o,
   output logic              hold_o
);

   ctl_t              ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign hold_o = ctl_q.valid && ctl_q.rnw && !rdy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '{valid: 1'b0, rnw: 1'b1, sync: 1'b0, rgn: RGN_INT};
         addr_q <= '0;
         data_q <= '0;
      end else if (!hold_o) begin
         ctl_q  <= nxt_ctl_i;
         addr_q <= nxt_addr_i;
         data_q <= nxt_data_i;
      end
   end

   assign cur_ctl_o  = ctl_q;
   assign cur_addr_o = addr_q;
   assign cur_data_o = data_q;

endmodule

// File: rtl/ebc_drive.sv
module ebc_drive
   import ebc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter bit MIRROR_EN = 1'b1
) (
   input  ctl_t              cur_ctl_i,
   input  logic [ADDR_W-1:0] cur_addr_i,
   input  logic [DATA_W-1:0] cur_data_i,
   input  logic [DATA_W-1:0] ext_din_i,
   input  logic [DATA_W-1:0] int_rdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              int_sel_o,
   output logic              int_we_o,
   output logic [ADDR_W-1:0] ext_addr_o,
   output logic [DATA_W-1:0] ext_dout_o,
   output logic              ext_doe_o,
   output logic              ext_rnw_o,
   output logic              ext_strobe_o,
   output logic              ext_sync_o
);

   logic is_ext;
   logic is_int;
   logic mirror;
   logic visible;

   assign is_ext = cur_ctl_i.valid && (cur_ctl_i.rgn != RGN_INT);
   assign is_int = cur_ctl_i.valid && (cur_ctl_i.rgn == RGN_INT);

   if (MIRROR_EN) begin : g_mirror
      assign mirror = is_int && !cur_ctl_i.rnw;
   end else begin : g_nomirror
      assign mirror = 1'b0;
   end

   assign visible      = is_ext || mirror;
   assign ext_strobe_o = visible;
   assign ext_rnw_o    = visible ? cur_ctl_i.rnw : 1'b1;
   assign ext_addr_o   = visible ? cur_addr_i : '0;
   assign ext_doe_o    = visible && !cur_ctl_i.rnw;
   assign ext_dout_o   = ext_doe_o ? cur_data_i : '0;
   assign ext_sync_o   = cur_ctl_i.valid && cur_ctl_i.sync;

   assign int_sel_o    = is_int;
   assign int_we_o     = is_int && !cur_ctl_i.rnw;
   assign cpu_rdata_o  = is_ext ? ext_din_i : int_rdata_i;

endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
   import ebc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int PROG_LO   = 'h800,
   parameter int PROG_HI   = 'hFF9,
   parameter int DBG_LO    = 'h400,
   parameter int DBG_HI    = 'h7FF,
   parameter bit DBG_EN    = 1'b1,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic              cpu_rnw_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   input  logic              cpu_sync_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              cpu_stall_o,
   input  logic [DATA_W-1:0] int_rdata_i,
   output logic              int_sel_o,
   output logic              int_we_o,
   output logic [ADDR_W-1:0] ext_addr_o,
   output logic [DATA_W-1:0] ext_dout_o,
   output logic              ext_doe_o,
   input  logic [DATA_W-1:0] ext_din_i,
   output logic              ext_rnw_o,
   output logic              ext_strobe_o,
   output logic              ext_sync_o,
   input  logic              ext_rdy_i
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (PROG_HI >= ADDR_SPAN) begin : g_bad_span
      $error("program window exceeds the address space");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("data width must be positive");
   end

   rgn_e              nxt_rgn;
   ctl_t              nxt_ctl;
   ctl_t              cur_ctl;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_data;

   ebc_decode #(
      .ADDR_W (ADDR_W), .PROG_LO(PROG_LO), .PROG_HI(PROG_HI),
      .DBG_LO (DBG_LO), .DBG_HI (DBG_HI),  .DBG_EN (DBG_EN)
   ) u_dec (
      .addr_i (cpu_addr_i),
      .rgn_o  (nxt_rgn)
   );

   assign nxt_ctl = '{valid: cpu_valid_i, rnw: cpu_rnw_i,
                      sync: cpu_sync_i, rgn: nxt_rgn};

   ebc_cycle_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .rdy_i      (ext_rdy_i),
      .nxt_ctl_i  (nxt_ctl),
      .nxt_addr_i (cpu_addr_i),
      .nxt_data_i (cpu_wdata_i),
      .cur_ctl_o  (cur_ctl),
      .cur_addr_o (cur_addr),
      .cur_data_o (cur_data),
      .hold_o     (cpu_stall_o)
   );

   ebc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIRROR_EN(MIRROR_EN)) u_drv (
      .cur_ctl_i    (cur_ctl),
      .cur_addr_i   (cur_addr),
      .cur_data_i   (cur_data),
      .ext_din_i    (ext_din_i),
      .int_rdata_i  (int_rdata_i),
      .cpu_rdata_o  (cpu_rdata_o),
      .int_sel_o    (int_sel_o),
      .int_we_o     (int_we_o),
      .ext_addr_o   (ext_addr_o),
      .ext_dout_o   (ext_dout_o),
      .ext_doe_o    (ext_doe_o),
      .ext_rnw_o    (ext_rnw_o),
      .ext_strobe_o (ext_strobe_o),
      .ext_sync_o   (ext_sync_o)
   );

   AST_STALL_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall_o |=> ($stable(ext_addr_o) && $stable(ext_strobe_o) && $stable(int_sel_o))); // R8
   AST_STALL_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall_o |-> (!ext_rdy_i && ext_rnw_o && !ext_doe_o)); // R8
   AST_INT_READ_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sel_o && !int_we_o) |-> !ext_strobe_o); // R3
   AST_MIRROR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_we_o && MIRROR_EN) |-> (ext_strobe_o && ext_doe_o && !ext_rnw_o)); // R4
   AST_DOE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_doe_o |-> (ext_strobe_o && !ext_rnw_o)); // R5
   AST_EXT_WR_NOT_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_doe_o && !int_sel_o) |-> !int_we_o); // R6
   AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_valid_i && !cpu_stall_o) |=> (!ext_strobe_o && !int_sel_o && !ext_sync_o)); // R10

endmodule

// File: tb/sim_ebc_bus_ctrl.sv
module sim_ebc_bus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid_i = 1'b0;
   logic [11:0] cpu_addr_i = '0;
   logic        cpu_rnw_i = 1'b1;
   logic [7:0]  cpu_wdata_i = '0;
   logic        cpu_sync_i = 1'b0;
   logic [7:0]  cpu_rdata_o;
   logic        cpu_stall_o;
   logic [7:0]  int_rdata_i = '0;
   logic        int_sel_o;
   logic        int_we_o;
   logic [11:0] ext_addr_o;
   logic [7:0]  ext_dout_o;
   logic        ext_doe_o;
   logic [7:0]  ext_din_i = '0;
   logic        ext_rnw_o;
   logic        ext_strobe_o;
   logic        ext_sync_o;
   logic        ext_rdy_i = 1'b1;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // bench model of the registered cycle
   logic        m_valid = 1'b0;
   logic        m_rnw = 1'b1;
   logic        m_sync = 1'b0;
   logic [11:0] m_addr = '0;
   logic [7:0]  m_data = '0;

   always #10 clk = ~clk;

   ebc_bus_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid_i(cpu_valid_i), .cpu_addr_i(cpu_addr_i), .cpu_rnw_i(cpu_rnw_i),
      .cpu_wdata_i(cpu_wdata_i), .cpu_sync_i(cpu_sync_i),
      .cpu_rdata_o(cpu_rdata_o), .cpu_stall_o(cpu_stall_o),
      .int_rdata_i(int_rdata_i), .int_sel_o(int_sel_o), .int_we_o(int_we_o),
      .ext_addr_o(ext_addr_o), .ext_dout_o(ext_dout_o), .ext_doe_o(ext_doe_o),
      .ext_din_i(ext_din_i), .ext_rnw_o(ext_rnw_o), .ext_strobe_o(ext_strobe_o),
      .ext_sync_o(ext_sync_o), .ext_rdy_i(ext_rdy_i)
   );

   function automatic bit f_ext(input logic [11:0] a);
      return ((a >= 12'h800) && (a <= 12'hFF9)) || ((a >= 12'h400) && (a <= 12'h7FF));
   endfunction

   function automatic string f_tag(input logic [11:0] a, input logic v, input logic rnw);
      if (!v) return "R10";
      if ((a >= 12'h400) && (a <= 12'h7FF)) return "R2";
      if (f_ext(a)) return rnw ? "R1" : "R6";
      return rnw ? "R3" : "R4";
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      bit    ext = f_ext(m_addr);
      bit    vis = m_valid && (ext || !m_rnw);
      bit    doe = vis && !m_rnw;
      bit    isel = m_valid && !ext;
      string t = f_tag(m_addr, m_valid, m_rnw);
      chk(t, "strobe", int'(ext_strobe_o), int'(vis));
      chk(t, "rnw", int'(ext_rnw_o), int'(vis ? m_rnw : 1'b1));
      chk(t, "addr", int'(ext_addr_o), int'(vis ? m_addr : 12'h0));
      chk("R5", "doe", int'(ext_doe_o), int'(doe));
      chk("R5", "dout", int'(ext_dout_o), int'(doe ? m_data : 8'h0));
      chk("R7", "sync", int'(ext_sync_o), int'(m_valid && m_sync));
      chk(t, "int_sel", int'(int_sel_o), int'(isel));
      chk(t, "int_we", int'(int_we_o), int'(isel && !m_rnw));
      chk(t, "rdata", int'(cpu_rdata_o), int'((m_valid && ext) ? ext_din_i : int_rdata_i));
      chk("R8", "stall", int'(cpu_stall_o), int'(m_valid && m_rnw && !ext_rdy_i));
   endtask

   // drive at negedge, register at posedge, check at the following negedge
   task automatic step(input logic v, input logic [11:0] a, input logic rnw,
                       input logic [7:0] wd, input logic sy, input logic rdy);
      bit hold;
      cpu_valid_i = v; cpu_addr_i = a; cpu_rnw_i = rnw;
      cpu_wdata_i = wd; cpu_sync_i = sy; ext_rdy_i = rdy;
      ext_din_i = 8'($urandom); int_rdata_i = 8'($urandom);
      hold = m_valid && m_rnw && !rdy;
      @(posedge clk);
      if (!hold) begin
         m_valid = v; m_rnw = rnw; m_sync = sy; m_addr = a; m_data = wd;
      end
      @(negedge clk);
      ext_din_i = 8'($urandom); int_rdata_i = 8'($urandom);
      #1;
      check_outputs();
   endtask

   function automatic logic [11:0] pick_addr();
      logic [11:0] edges [6] = '{12'h3FF, 12'h400, 12'h7FF, 12'h800, 12'hFF9, 12'hFFA};
      int k = int'($urandom % 8);
      if (k < 6) return edges[k] + 12'(int'($urandom % 3) - 1);
      return 12'($urandom);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20871));
      // R9: idle during reset
      repeat (3) @(negedge clk);
      chk("R9", "strobe", int'(ext_strobe_o), 0);
      chk("R9", "rnw", int'(ext_rnw_o), 1);
      chk("R9", "doe", int'(ext_doe_o), 0);
      chk("R9", "sync", int'(ext_sync_o), 0);
      chk("R9", "int_sel", int'(int_sel_o), 0);
      chk("R9", "stall", int'(cpu_stall_o), 0);
      rst_n = 1'b1;
      // directed window edges, reads then writes
      step(1, 12'h800, 1, 8'h00, 1, 1);   // R1 with R7 fetch
      step(1, 12'hFF9, 1, 8'h00, 0, 1);   // R1 top edge
      step(1, 12'hFFA, 1, 8'h00, 1, 1);   // R3 vector area, R7 internal fetch
      step(1, 12'h7FF, 1, 8'h00, 0, 1);   // R2
      step(1, 12'h400, 1, 8'h00, 0, 1);   // R2 low edge
      step(1, 12'h3FF, 1, 8'h00, 0, 1);   // R3
      step(1, 12'h010, 0, 8'hA5, 0, 1);   // R4 mirrored write
      step(1, 12'hFFF, 0, 8'h3C, 0, 1);   // R4 vector write
      step(1, 12'h900, 0, 8'h5A, 0, 0);   // R6, R8 rdy ignored on write
      step(0, 12'h900, 1, 8'h00, 0, 1);   // R10 gap
      // R8: stretched external read with changing core inputs
      step(1, 12'hA00, 1, 8'h00, 0, 1);
      step(1, 12'h020, 0, 8'h77, 0, 0);
      step(1, 12'h030, 0, 8'h66, 1, 0);
      step(1, 12'h030, 0, 8'h66, 1, 1);
      step(1, 12'h040, 1, 8'h00, 0, 1);
      // R8: stretched internal read
      step(1, 12'h0C0, 0, 8'h11, 0, 0);
      step(1, 12'h050, 1, 8'h00, 0, 0);
      step(1, 12'h060, 1, 8'h00, 0, 1);
      for (int i = 0; i < 600; i++) begin
         step(1'($urandom % 8 != 0), pick_addr(), 1'($urandom), 8'($urandom),
              1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
      end
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule